// File: doc/BRIEF.md
# Binary Search Tree Join Controller

This block is the per-channel engine of a hardware equi-join. It owns a dual-port node table and keeps one unbalanced binary search tree in it. During the build phase, it takes `{id, key}` tuples from an upstream queue and links each one into the tree as a new node. During the probe phase, it takes tuples from the other relation, walks the tree from the root, and sends one `{ida, idb, key}` result for every stored node whose key equals the probe key.

A node holds an id, a key, and two child pointers. A reserved all-ones pointer value marks a missing child. The first build tuple becomes the root at address 0. Later nodes are placed at an address counter that only increments. Equal keys are sent to the right subtree, so the nodes for a repeated key form a chain going right. For this reason a probe continues walking after a match. The phase input is sampled per tuple at acceptance. Results leave through a valid/ready port, and the walk pauses while that port is blocked.

Top module: `bst_join_ctrl`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the node table is empty.
- R2: Each accepted build tuple becomes exactly one new node, and the first one becomes the root at address 0. A probe against an empty tree gives no result, and `in_ready` is high again in the cycle after the acceptance.
- R3: A key smaller than a node's key goes to the left child. A key equal to or greater than the node's key goes to the right child. A probe reports every stored node whose key equals the probe key, in the order those nodes were inserted, and reports nothing else.
- R4: In each result, `out_ida` is the stored node's id, `out_idb` is the probe tuple's id and `out_key` is the matching key.
- R5: Each comparison takes two clocks, one to read a node and one to compare. For a first match at depth d (the root is depth 0), `out_valid` first reads high after the (2d+3)th rising edge, counting the edge that accepts the tuple as the first.
- R6: While `out_valid` is high and `out_ready` is low, the result fields hold their values and `in_ready` stays low.
- R7: Once DEPTH nodes are stored, a further build tuple is consumed with `in_ready` high again in the next cycle, and it is not added to the tree.
- R8: The phase is captured together with each tuple when that tuple is accepted. Changing `phase_probe` during a walk does not change how that tuple is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_probe | input | 1 | 1 = probe phase, 0 = build phase; sampled with each tuple |
| in_valid | input | 1 | Upstream queue has a tuple |
| in_ready | output | 1 | Controller pops the tuple this cycle |
| in_id | input | IDW | Tuple id |
| in_key | input | KW | Tuple join key |
| out_valid | output | 1 | Join result is available |
| out_ready | input | 1 | Downstream accepts the result |
| out_ida | output | IDW | Id of the matching stored node |
| out_idb | output | IDW | Id of the probe tuple |
| out_key | output | KW | Matching key |

## Verification
A corrupted child pointer or misplaced node shows up at the ports as a missing, extra or reordered result, or as a first result arriving later or earlier than 2d+3 edges. It is seen on the first probe whose walk passes through the damaged node. A stale address counter or a broken full flag shows up when a key that was inserted, or should have been discarded, is probed later. The bench builds a small tree with repeated keys and then probes every possible key value. This exposes any such state within one sweep.

// File: rtl/bst_join_pkg.sv
package bst_join_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GETCHILD,
    ST_COMPARE,
    ST_INSERT,
    ST_EMIT
  } bst_state_e;
endpackage

// File: rtl/bst_node_ram.sv
module bst_node_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata
);
  logic [DW-1:0] mem [DEPTH];

  // Port A: write or registered read; port B: write only.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    else if (a_re) a_rdata <= mem[a_addr];
    if (b_we) mem[b_addr] <= b_wdata;
  end
endmodule

// File: rtl/bst_key_cmp.sv
module bst_key_cmp #(
  parameter int KW = 32
) (
  input  logic [KW-1:0] probe_key,
  input  logic [KW-1:0] node_key,
  output logic          go_left,
  output logic          equal
);
  always_comb begin
    go_left = probe_key < node_key;
    equal   = probe_key == node_key;
  end
endmodule

// File: rtl/bst_free_ptr.sv
module bst_free_ptr #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  output logic [AW-1:0] next_addr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] FULL_V = CW'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (alloc && count != FULL_V) count <= count + CW'(1);
  end

  always_comb begin
    next_addr = count[AW-1:0];
    full      = count == FULL_V;
    empty     = count == '0;
  end
endmodule

// File: rtl/bst_join_ctrl.sv
module bst_join_ctrl
  import bst_join_pkg::*;
#(
  parameter int IDW   = 16,
  parameter int KW    = 32,
  parameter int DEPTH = 512
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           phase_probe,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [IDW-1:0] in_id,
  input  logic [KW-1:0]  in_key,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [IDW-1:0] out_ida,
  output logic [IDW-1:0] out_idb,
  output logic [KW-1:0]  out_key
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = AW + 1;
  localparam int DW = IDW + KW + 2 * PW;
  localparam logic [PW-1:0] NULLP = '1;

  bst_state_e      state;
  logic [IDW-1:0]  cur_id;
  logic [KW-1:0]   cur_key;
  logic            cur_probe;
  logic [PW-1:0]   cur_ptr;
  logic            ins_left;
  logic            has_parent;

  logic            a_we, a_re, b_we;
  logic [AW-1:0]   a_addr, b_addr;
  logic [DW-1:0]   a_wdata, b_wdata, node_q;

  logic [IDW-1:0]  node_id;
  logic [KW-1:0]   node_key;
  logic [PW-1:0]   node_lpt, node_rpt, child, new_ptr;
  logic            key_lt, key_eq, child_null;

  logic            alloc_go, tree_full, tree_empty;
  logic [AW-1:0]   alloc_addr;
  logic [CW-1:0]   node_count;

  assign node_rpt = node_q[PW-1:0];
  assign node_lpt = node_q[2*PW-1:PW];
  assign node_key = node_q[2*PW+KW-1:2*PW];
  assign node_id  = node_q[DW-1:2*PW+KW];

  bst_node_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .a_we(a_we), .a_re(a_re), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(node_q), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata)
  );

  bst_key_cmp #(.KW(KW)) u_cmp (
    .probe_key(cur_key), .node_key(node_key), .go_left(key_lt), .equal(key_eq)
  );

  bst_free_ptr #(.DEPTH(DEPTH)) u_free (
    .clk(clk), .rst(rst), .alloc(alloc_go), .next_addr(alloc_addr),
    .count(node_count), .full(tree_full), .empty(tree_empty)
  );

  always_comb begin
    child      = key_lt ? node_lpt : node_rpt;
    child_null = child == NULLP;
    new_ptr    = {1'b0, alloc_addr};
    in_ready   = state == ST_IDLE;
    alloc_go   = state == ST_INSERT;
    a_we       = state == ST_INSERT;
    a_re       = state == ST_GETCHILD;
    a_addr     = a_we ? alloc_addr : cur_ptr[AW-1:0];
    a_wdata    = {cur_id, cur_key, NULLP, NULLP};
    b_we       = (state == ST_INSERT) && has_parent;
    b_addr     = cur_ptr[AW-1:0];
    b_wdata    = ins_left ? {node_id, node_key, new_ptr, node_rpt}
                          : {node_id, node_key, node_lpt, new_ptr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      out_valid  <= 1'b0;
      out_ida    <= '0;
      out_idb    <= '0;
      out_key    <= '0;
      cur_id     <= '0;
      cur_key    <= '0;
      cur_probe  <= 1'b0;
      cur_ptr    <= NULLP;
      ins_left   <= 1'b0;
      has_parent <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            cur_id    <= in_id;
            cur_key   <= in_key;
            cur_probe <= phase_probe;
            if (phase_probe) begin
              if (!tree_empty) begin
                cur_ptr <= '0;
                state   <= ST_GETCHILD;
              end
            end else if (tree_empty) begin
              has_parent <= 1'b0;
              state      <= ST_INSERT;
            end else if (!tree_full) begin
              has_parent <= 1'b1;
              cur_ptr    <= '0;
              state      <= ST_GETCHILD;
            end
          end
        end
        ST_GETCHILD: state <= ST_COMPARE;
        ST_COMPARE: begin
          if (cur_probe) begin
            if (key_eq) begin
              out_valid <= 1'b1;
              out_ida   <= node_id;
              out_idb   <= cur_id;
              out_key   <= cur_key;
              cur_ptr   <= child;
              state     <= ST_EMIT;
            end else if (child_null) begin
              state <= ST_IDLE;
            end else begin
              cur_ptr <= child;
              state   <= ST_GETCHILD;
            end
          end else if (child_null) begin
            ins_left <= key_lt;
            state    <= ST_INSERT;
          end else begin
            cur_ptr <= child;
            state   <= ST_GETCHILD;
          end
        end
        ST_INSERT: state <= ST_IDLE;
        ST_EMIT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= (cur_ptr == NULLP) ? ST_IDLE : ST_GETCHILD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bst_join_ctrl_chk.sv
module bst_join_ctrl_chk
  import bst_join_pkg::*;
#(
  parameter int IDW   = 16,
  parameter int KW    = 32,
  parameter int DEPTH = 512,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [IDW-1:0] out_ida,
  input logic [IDW-1:0] out_idb,
  input logic [KW-1:0]  out_key,
  input bst_state_e     state,
  input logic [CW-1:0]  node_count
);
  localparam logic [CW-1:0] MAXC = CW'(DEPTH);

  // R1: the cycle after reset shows no result and a ready input
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  // R2: the node count only ever steps up by one
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (node_count != $past(node_count)) |-> (node_count == $past(node_count) + CW'(1)));

  // R5: every compare is preceded by a node read cycle
  a_r5_two_cycle_cmp: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COMPARE) |-> ($past(state) == ST_GETCHILD));

  // R6: a blocked result holds its fields
  a_r6_hold_result: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ida) &&
                                   $stable(out_idb) && $stable(out_key)));

  // R6: no tuple is popped while a result is pending
  a_r6_no_pop_pending: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R7: the table never holds more than DEPTH nodes
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    node_count <= MAXC);
endmodule

bind bst_join_ctrl bst_join_ctrl_chk #(.IDW(IDW), .KW(KW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_ida(out_ida), .out_idb(out_idb), .out_key(out_key),
  .state(state), .node_count(node_count)
);

// File: tb/test_bst_join_ctrl.sv
module test_bst_join_ctrl;
  localparam int IDW = 6;
  localparam int KW  = 8;
  localparam int DEP = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase_probe = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IDW-1:0] in_id = '0;
  logic [KW-1:0]  in_key = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [IDW-1:0] out_ida, out_idb;
  logic [KW-1:0]  out_key;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  logic [KW-1:0]  bk [DEP];
  logic [IDW-1:0] bi [DEP];
  int nb = 0;

  always #4 clk = ~clk;

  bst_join_ctrl #(.IDW(IDW), .KW(KW), .DEPTH(DEP)) i_bst_join_ctrl (
    .clk(clk), .rst(rst), .phase_probe(phase_probe), .in_valid(in_valid),
    .in_ready(in_ready), .in_id(in_id), .in_key(in_key), .out_valid(out_valid),
    .out_ready(out_ready), .out_ida(out_ida), .out_idb(out_idb), .out_key(out_key)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      check(0, "watchdog", "run did not finish", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_idle();
    for (int t = 0; t < 300 && !in_ready; t++) @(negedge clk);
  endtask

  function automatic int count_exp(input logic [KW-1:0] key);
    int c = 0;
    for (int i = 0; i < nb; i++) if (bk[i] == key) c++;
    return c;
  endfunction

  task automatic build(input logic [IDW-1:0] id, input logic [KW-1:0] key);
    wait_idle();
    phase_probe = 1'b0; in_valid = 1'b1; in_id = id; in_key = key;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    if (nb < DEP) begin bk[nb] = key; bi[nb] = id; nb++; end
  endtask

  // Probe one key; check every result against the insertion-ordered model.
  task automatic do_probe(input logic [KW-1:0] key, input int exp_lat,
                          input bit flip, input bit bp, input string tag);
    int j = 0;
    int n = 1;
    int first_n = 0;
    int got = 0;
    logic [IDW-1:0] pid = key[IDW-1:0] ^ 6'h2a;
    wait_idle();
    out_ready = 1'b1;
    phase_probe = 1'b1; in_valid = 1'b1; in_id = pid; in_key = key;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    if (flip) phase_probe = 1'b0;
    while (n < 400) begin
      if (out_valid && out_ready) begin
        if (first_n == 0) first_n = n;
        while (j < nb && bk[j] != key) j++;
        if (j >= nb) check(0, tag, "unexpected result ida", int'(out_ida), -1);
        else begin
          check(out_ida == bi[j], tag, "R4 result ida", int'(out_ida), int'(bi[j]));
          check({out_idb, out_key} == {pid, key}, tag, "R4 result idb/key",
                int'({out_idb, out_key}), int'({pid, key}));
          j++;
        end
        got++;
      end
      if (in_ready && !out_valid) break;
      @(negedge clk); n++;
      out_ready = bp ? n[0] : 1'b1;
    end
    out_ready = 1'b1;
    check(got == count_exp(key), tag, "R3 result count", got, count_exp(key));
    if (exp_lat > 0) check(first_n == exp_lat, tag, "R5 first result edge", first_n, exp_lat);
    phase_probe = 1'b1;
  endtask

  initial begin
    logic [IDW-1:0] hold_id;
    int k;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

    // R2: probe against an empty tree
    phase_probe = 1'b1; in_valid = 1'b1; in_id = 6'd5; in_key = 8'd7;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check(in_ready && !out_valid, "R2", "empty probe refetch", int'(in_ready), 1);
    k = 0;
    for (int t = 0; t < 6; t++) begin if (out_valid) k++; @(negedge clk); end
    check(k == 0, "R2", "empty probe results", k, 0);

    // Build first 8 nodes: keys ((i*5)%9)*30, ids (i*3+1)%64
    for (int i = 0; i < 8; i++) build(6'((i * 3 + 1) % 64), 8'(((i * 5) % 9) * 30));

    // R2/R5: root at depth 0, 150 at depth 1, 30 at depth 2
    do_probe(8'd0,   3, 0, 0, "R5");
    do_probe(8'd150, 5, 0, 0, "R5");
    do_probe(8'd30,  7, 0, 0, "R5");
    // R8: phase flipped during the walk; a second probe shows no insert happened
    do_probe(8'd30,  7, 1, 0, "R8");
    do_probe(8'd30,  0, 0, 0, "R8");

    for (int i = 8; i < 16; i++) build(6'((i * 3 + 1) % 64), 8'(((i * 5) % 9) * 30));

    // R6: stall the first result of key 0 (two stored copies)
    wait_idle();
    out_ready = 1'b0;
    phase_probe = 1'b1; in_valid = 1'b1; in_id = 6'd9; in_key = 8'd0;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    for (int t = 0; t < 50 && !out_valid; t++) @(negedge clk);
    hold_id = out_ida;
    check(out_ida == bi[0], "R6", "first stalled ida", int'(out_ida), int'(bi[0]));
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      check(out_valid && out_ida == hold_id && !in_ready, "R6", "held result",
            int'(out_valid), 1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    for (int t = 0; t < 50 && !out_valid; t++) @(negedge clk);
    check(out_ida == bi[9], "R3", "duplicate in insertion order", int'(out_ida), int'(bi[9]));
    wait_idle();

    // R7: full table drops a further build tuple
    build(6'd63, 8'd255);
    check(in_ready, "R7", "drop refetch when full", int'(in_ready), 1);
    do_probe(8'd255, 0, 0, 0, "R7");

    // R3/R4: sweep every key, alternate backpressure
    for (int key = 0; key < 256; key++) do_probe(8'(key), 0, 0, key[0], "R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule